// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block turns a serial bit stream into parallel words. A frame begins with a pulse on the frame-sync line. After a selectable delay of 0, 1 or 2 bit ticks, the receiver samples one data bit on every clock cycle in which the bit-clock enable is high. It collects these bits into words of one of six lengths. A frame holds a programmable number of words, from 1 to 128. Each finished word is formatted according to the justification mode, or bit-reversed when that option applies. The formatted word is placed in a 32-bit read register, and a ready flag rises. That flag can serve directly as the receive interrupt, and the consumer clears it with a one-cycle read acknowledge.

A frame pulse can arrive while a frame is still being received. A configuration bit selects what happens. The receiver can ignore such a pulse. Otherwise it restarts reception at that pulse and raises a sticky sync-error flag.

The receiver is driven by a control state machine with three states:
- `ST_IDLE`: waits for a frame pulse.
- `ST_DELAY`: counts off the data delay.
- `ST_SHIFT`: samples data bits.

Its transitions are:
- **start** (IDLE to DELAY, or IDLE to SHIFT when the delay is 0).
- **delay-done** (DELAY to SHIFT).
- **next-word** (SHIFT to SHIFT).
- **frame-end** (SHIFT to IDLE).
- **restart**: an early pulse that is not ignored. It goes from DELAY or SHIFT back to DELAY or SHIFT.
- **hold**: from any state to IDLE.

Top module: `serial_frame_rx`

## Requirements
- R1: Word-length code `wlen_code` selects the number of bits per word: 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6 or 7 give 32. A word completes after exactly that many sampled bits.
- R2: Delay code `dly_code` places the first data bit relative to the tick that carries the frame pulse. Code 0 samples the first bit on that same tick, code 1 on the next tick, and code 2 or 3 on the tick after that.
- R3: Unless bit reversal applies, the first bit received of each word is the word's most significant bit.
- R4: Justification code `just_code` formats a word of W bits when reversal does not apply, as follows:
  - Code 0 and code 3: the value sits in bits W-1..0, and the upper bits are zero.
  - Code 1: the value sits in bits W-1..0, and the upper bits copy bit W-1.
  - Code 2: the value sits in bits 31..32-W, and the lower bits are zero.
- R5: With `lsb_first` high and a 32-bit word length, the first bit received becomes bit 0 of the read register, and `just_code` has no effect. With any other word length, `lsb_first` has no effect.
- R6: A frame holds `frame_words`+1 words. After the last word the receiver returns to idle, and further bit ticks without a frame pulse produce no word.
- R7: With `ignore_early` high, a frame pulse that arrives during a frame has no effect. The words are received unchanged, and `sync_err` stays low.
- R8: With `ignore_early` low, a frame pulse that arrives during a frame discards the partial word and starts a new frame at that tick. It also sets `sync_err`, which stays high until `rx_hold` or reset.
- R9: `rd_ready` rises on the clock edge that completes a word, together with the new `rd_data`. It falls on the edge where `rd_ack` is high and no word completes.
- R10: While `rx_hold` is high, the receiver stays idle and ignores frame pulses and data. It also clears `rd_ready`, `rd_data` and `sync_err`.
- R11: Frame sync and data are sampled only in cycles where `bit_en` is high. Their values in other cycles have no effect.
- R12: After reset, `rd_data` is zero and `rd_ready` and `sync_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_hold | input | 1 | Receiver reset; holds the block idle and cleared |
| bit_en | input | 1 | Bit-clock tick enable |
| sdata | input | 1 | Serial data line |
| fsync | input | 1 | Frame-sync pulse, active high |
| wlen_code | input | 3 | Word-length select |
| dly_code | input | 2 | Data-delay select |
| ignore_early | input | 1 | 1: ignore early frame pulses; 0: restart on them |
| just_code | input | 2 | Justification / sign-extension mode |
| lsb_first | input | 1 | LSB-first reversal for 32-bit words |
| frame_words | input | 7 | Words per frame minus one |
| rd_ack | input | 1 | Read acknowledge; clears the ready flag |
| rd_data | output | 32 | Read register |
| rd_ready | output | 1 | Word-ready flag / receive interrupt |
| sync_err | output | 1 | Sticky frame-sync error flag |

## Verification
The bench sweeps every combination of word length, delay and justification code, each with and without bit reversal. Each frame carries two hashed words whose top bits vary, so the sweep separates sign extension from zero fill, and left placement from right placement. It also shows that reversal takes effect only at 32 bits.

Frame pulses are also sent in the middle of a frame, once with ignore set and once with it clear. These runs separate a frame that continues from one that restarts and flags an error. A four-word frame followed by trailing ticks checks that the word count ends the frame.

Throughout the run, the idle cycles between ticks carry inverted data and a raised frame sync. This shows that only enabled ticks are sampled.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int WORD_W = 32;
    localparam int BCNT_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_SHIFT = 2'd2
    } rx_state_e;

    // word length in bits for a length code; codes above 5 select 32
    function automatic logic [BCNT_W-1:0] wlen_bits(input logic [2:0] code);
        logic [BCNT_W-1:0] b;
        unique case (code)
            3'd0:    b = 6'd8;
            3'd1:    b = 6'd12;
            3'd2:    b = 6'd16;
            3'd3:    b = 6'd20;
            3'd4:    b = 6'd24;
            default: b = 6'd32;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
    import sfr_pkg::*;
#(
    parameter int WCNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              bit_en,
    input  logic              fsync,
    input  logic [2:0]        wlen_code,
    input  logic [1:0]        dly_code,
    input  logic              ignore_early,
    input  logic [WCNT_W-1:0] frame_words,
    output logic              shift_en,
    output logic              word_done,
    output logic              sync_err
);

    rx_state_e         state_q, state_n;
    logic [BCNT_W-1:0] bitcnt_q, bitcnt_n;
    logic [WCNT_W-1:0] wordcnt_q, wordcnt_n;
    logic [1:0]        dlycnt_q, dlycnt_n;
    logic              err_q, err_n;

    logic              tick, busy, start;
    logic [1:0]        dly_eff;
    logic [BCNT_W-1:0] wbits;

    always_comb begin
        tick    = bit_en & ~hold;
        busy    = (state_q != ST_IDLE);
        start   = tick & fsync & (~busy | ~ignore_early);
        dly_eff = (dly_code == 2'd3) ? 2'd2 : dly_code;
        wbits   = wlen_bits(wlen_code);
    end

    // next-state and output process
    always_comb begin
        state_n   = state_q;
        bitcnt_n  = bitcnt_q;
        wordcnt_n = wordcnt_q;
        dlycnt_n  = dlycnt_q;
        err_n     = err_q | (start & busy);
        shift_en  = 1'b0;
        word_done = 1'b0;
        if (start) begin
            wordcnt_n = '0;
            bitcnt_n  = '0;
            if (dly_eff == 2'd0) begin
                shift_en = 1'b1;
                bitcnt_n = 6'd1;
                state_n  = ST_SHIFT;
            end else begin
                dlycnt_n = 2'(dly_eff - 2'd1);
                state_n  = ST_DELAY;
            end
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_DELAY: begin
                    if (dlycnt_q == 2'd0) begin
                        shift_en = 1'b1;
                        bitcnt_n = 6'd1;
                        state_n  = ST_SHIFT;
                    end else begin
                        dlycnt_n = 2'(dlycnt_q - 2'd1);
                    end
                end
                ST_SHIFT: begin
                    shift_en = 1'b1;
                    if (6'(bitcnt_q + 6'd1) >= wbits) begin
                        word_done = 1'b1;
                        bitcnt_n  = '0;
                        if (wordcnt_q == frame_words) begin
                            wordcnt_n = '0;
                            state_n   = ST_IDLE;
                        end else begin
                            wordcnt_n = WCNT_W'(wordcnt_q + 1'b1);
                        end
                    end else begin
                        bitcnt_n = 6'(bitcnt_q + 6'd1);
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bitcnt_q  <= '0;
            wordcnt_q <= '0;
            dlycnt_q  <= '0;
            err_q     <= 1'b0;
        end else if (hold) begin
            state_q   <= ST_IDLE;
            bitcnt_q  <= '0;
            wordcnt_q <= '0;
            dlycnt_q  <= '0;
            err_q     <= 1'b0;
        end else begin
            state_q   <= state_n;
            bitcnt_q  <= bitcnt_n;
            wordcnt_q <= wordcnt_n;
            dlycnt_q  <= dlycnt_n;
            err_q     <= err_n;
        end
    end

    assign sync_err = err_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state_q == ST_IDLE) && !err_q); // R10
    AST_NO_SAMPLE_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |-> !shift_en && !word_done); // R11
    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt_q < 6'd32); // R1
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(fsync && bit_en && !ignore_early)); // R8
    AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !fsync |-> !word_done); // R6

endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              shift_en,
    input  logic              sdata,
    output logic [WORD_W-1:0] word_nxt
);

    logic [WORD_W-2:0] sr_q;

    assign word_nxt = {sr_q, sdata};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (hold)
            sr_q <= '0;
        else if (shift_en)
            sr_q <= word_nxt[WORD_W-2:0];
    end

endmodule

// File: rtl/sfr_readreg.sv
module sfr_readreg
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              load,
    input  logic [WORD_W-1:0] raw,
    input  logic [2:0]        wlen_code,
    input  logic [1:0]        just_code,
    input  logic              lsb_first,
    input  logic              rd_ack,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_ready
);

    logic [WORD_W-1:0] rev, mask, val, fmt;
    logic [BCNT_W-1:0] wbits;
    logic              sign;

    generate
        for (genvar i = 0; i < WORD_W; i++) begin : g_rev
            assign rev[i] = raw[WORD_W-1-i];
        end
    endgenerate

    always_comb begin
        wbits = wlen_bits(wlen_code);
        mask  = (32'h1 << wbits) - 32'h1;
        val   = raw & mask;
        sign  = raw[5'(wbits - 6'd1)];
        if ((wbits == 6'd32) && lsb_first) begin
            fmt = rev;
        end else begin
            unique case (just_code)
                2'd1:    fmt = sign ? (val | ~mask) : val;
                2'd2:    fmt = val << (6'd32 - wbits);
                default: fmt = val;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_ready <= 1'b0;
        end else if (hold) begin
            rd_data  <= '0;
            rd_ready <= 1'b0;
        end else if (load) begin
            rd_data  <= fmt;
            rd_ready <= 1'b1;
        end else if (rd_ack) begin
            rd_ready <= 1'b0;
        end
    end

    AST_READY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load && !hold |=> rd_ready); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && !load && !hold |=> !rd_ready); // R9
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !hold |=> $stable(rd_data)); // R9

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import sfr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_hold,
    input  logic        bit_en,
    input  logic        sdata,
    input  logic        fsync,
    input  logic [2:0]  wlen_code,
    input  logic [1:0]  dly_code,
    input  logic        ignore_early,
    input  logic [1:0]  just_code,
    input  logic        lsb_first,
    input  logic [6:0]  frame_words,
    input  logic        rd_ack,
    output logic [31:0] rd_data,
    output logic        rd_ready,
    output logic        sync_err
);

    logic              shift_en, word_done;
    logic [WORD_W-1:0] word_nxt;

    sfr_ctrl #(.WCNT_W(7)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold         (rx_hold),
        .bit_en       (bit_en),
        .fsync        (fsync),
        .wlen_code    (wlen_code),
        .dly_code     (dly_code),
        .ignore_early (ignore_early),
        .frame_words  (frame_words),
        .shift_en     (shift_en),
        .word_done    (word_done),
        .sync_err     (sync_err)
    );

    sfr_shifter i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (rx_hold),
        .shift_en (shift_en),
        .sdata    (sdata),
        .word_nxt (word_nxt)
    );

    sfr_readreg i_rreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (rx_hold),
        .load      (word_done),
        .raw       (word_nxt),
        .wlen_code (wlen_code),
        .just_code (just_code),
        .lsb_first (lsb_first),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .rd_ready  (rd_ready)
    );

endmodule

// File: tb/test_serial_frame_rx.sv
module test_serial_frame_rx;

    logic        clk = 1'b0;
    logic        rst_n, rx_hold, bit_en, sdata, fsync;
    logic [2:0]  wlen_code;
    logic [1:0]  dly_code, just_code;
    logic        ignore_early, lsb_first, rd_ack;
    logic [6:0]  frame_words;
    logic [31:0] rd_data;
    logic        rd_ready, sync_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    serial_frame_rx i_serial_frame_rx (
        .clk(clk), .rst_n(rst_n), .rx_hold(rx_hold), .bit_en(bit_en),
        .sdata(sdata), .fsync(fsync), .wlen_code(wlen_code),
        .dly_code(dly_code), .ignore_early(ignore_early),
        .just_code(just_code), .lsb_first(lsb_first),
        .frame_words(frame_words), .rd_ack(rd_ack),
        .rd_data(rd_data), .rd_ready(rd_ready), .sync_err(sync_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int wbits_of(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(input int w);
        return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    endfunction

    function automatic logic [31:0] val_of(input int seed, input int k, input int w);
        logic [31:0] h;
        h = 32'(seed) * 32'h9E37_79B9 + 32'(k) * 32'h7F4A_7C15 + 32'h1234_5678;
        h = h ^ (h >> 13);
        return h & mask_of(w);
    endfunction

    function automatic logic [31:0] exp_fmt(input logic [31:0] v, input int w,
                                            input logic [1:0] j, input logic r);
        if (r && w == 32) return v;
        case (j)
            2'd1: return v[w-1] ? (v | ~mask_of(w)) : v;
            2'd2: return v << (32 - w);
            default: return v;
        endcase
    endfunction

    // one enabled tick; the idle cycle after it carries a raised sync and inverted data (R11)
    task automatic tick(input logic fs, input logic d);
        @(negedge clk);
        bit_en = 1'b1; fsync = fs; sdata = d;
        @(negedge clk);
        bit_en = 1'b0; fsync = 1'b1; sdata = ~d;
    endtask

    task automatic ack();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    task automatic send_frame(input int nwords, input int seed, input int early_t, input string tag);
        int dlyv, w, total;
        dlyv  = (dly_code == 2'd3) ? 2 : int'(dly_code);
        w     = wbits_of(wlen_code);
        total = dlyv + nwords * w;
        for (int t = 0; t < total; t++) begin
            logic fs, d;
            logic [31:0] v;
            int j, k, p;
            fs = (t == 0) || (t == early_t);
            j = t - dlyv;
            k = (j >= 0) ? j / w : 0;
            p = (j >= 0) ? j % w : 0;
            v = val_of(seed, k, w);
            if (t < dlyv) d = t[0];
            else d = (lsb_first && w == 32) ? v[p] : v[w-1-p];
            tick(fs, d);
            if (t >= dlyv && p == w - 1) begin
                chk({tag, " ready"}, {31'd0, rd_ready}, 32'd1);
                chk({tag, " data"}, rd_data, exp_fmt(v, w, just_code, lsb_first));
                ack();
                chk({tag, " R9 ack"}, {31'd0, rd_ready}, 32'd0);
            end else if (t >= dlyv && p == 3) begin
                chk({tag, " R9 midword"}, {31'd0, rd_ready}, 32'd0);
            end
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R11 actual=timeout expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rx_hold = 1'b0; bit_en = 1'b0; sdata = 1'b0; fsync = 1'b0;
        wlen_code = 3'd0; dly_code = 2'd0; just_code = 2'd0; lsb_first = 1'b0;
        ignore_early = 1'b1; frame_words = 7'd1; rd_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 data", rd_data, 32'd0);
        chk("R12 ready", {31'd0, rd_ready}, 32'd0);
        chk("R12 err", {31'd0, sync_err}, 32'd0);

        // full sweep of lengths, delays, justification and reversal
        for (int wc = 0; wc < 6; wc++)
            for (int dc = 0; dc < 3; dc++)
                for (int jc = 0; jc < 3; jc++)
                    for (int rv = 0; rv < 2; rv++) begin
                        wlen_code = 3'(wc); dly_code = 2'(dc);
                        just_code = 2'(jc); lsb_first = rv[0];
                        send_frame(2, wc * 100 + dc * 10 + jc * 2 + rv, -1,
                            $sformatf("R1/R2/R3/R4/R5/R11 w%0d d%0d j%0d r%0d", wc, dc, jc, rv));
                    end
        chk("R7 no err in sweep", {31'd0, sync_err}, 32'd0);

        // out-of-range codes
        wlen_code = 3'd7; dly_code = 2'd3; just_code = 2'd3; lsb_first = 1'b0;
        send_frame(2, 77, -1, "R1/R2/R4 codes7-3-3");
        wlen_code = 3'd6; dly_code = 2'd0; just_code = 2'd1; lsb_first = 1'b1;
        send_frame(2, 78, -1, "R1/R5 code6 rev");

        // early pulse ignored
        wlen_code = 3'd0; dly_code = 2'd1; just_code = 2'd0; lsb_first = 1'b0;
        ignore_early = 1'b1; frame_words = 7'd1;
        send_frame(2, 5, 5, "R7 ignored");
        send_frame(2, 6, 12, "R7 ignored w1");
        chk("R7 err low", {31'd0, sync_err}, 32'd0);

        // early pulse restarts
        ignore_early = 1'b0; dly_code = 2'd0; frame_words = 7'd0;
        tick(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
        chk("R8 err before", {31'd0, sync_err}, 32'd0);
        for (int i = 7; i >= 0; i--) begin
            logic [7:0] b;
            b = 8'hA5;
            tick(i == 7, b[i]);
            if (i == 7) chk("R8 err set", {31'd0, sync_err}, 32'd1);
            if (i > 0) chk("R8 no early word", {31'd0, rd_ready}, 32'd0);
        end
        chk("R8 restart ready", {31'd0, rd_ready}, 32'd1);
        chk("R8 restart data", rd_data, 32'h0000_00A5);
        chk("R8 err sticky", {31'd0, sync_err}, 32'd1);

        // receiver hold
        @(negedge clk); rx_hold = 1'b1;
        for (int i = 0; i < 10; i++) tick(1'b1, 1'b1);
        chk("R10 ready clr", {31'd0, rd_ready}, 32'd0);
        chk("R10 err clr", {31'd0, sync_err}, 32'd0);
        chk("R10 data clr", rd_data, 32'd0);
        @(negedge clk); rx_hold = 1'b0;
        for (int i = 0; i < 10; i++) tick(1'b0, 1'b1);
        chk("R10 no word after hold", {31'd0, rd_ready}, 32'd0);
        ignore_early = 1'b1;
        send_frame(1, 9, -1, "R10 after release");

        // frame length and return to idle
        frame_words = 7'd3; dly_code = 2'd2; just_code = 2'd1;
        send_frame(4, 21, -1, "R6 four words");
        for (int i = 0; i < 40; i++) tick(1'b0, 1'b1);
        chk("R6 idle after frame", {31'd0, rd_ready}, 32'd0);

        finished = 1;
        summary();
        $finish;
    end

endmodule